// File: doc/BRIEF.md
# Low-First PWM Timer Core

This block produces one pulse-width-modulated output inside its own PWM clock domain. A 24-bit up-counter advances on ticks from a selectable clock divider, runs from zero to a programmed cycle value, and then wraps. Each period opens with a low phase whose length in ticks comes from a low-width input. The output then stays high for the rest of the period. A polarity input swaps the two levels, so the period starts with the high part.

The control fields reach the core already synchronized to the PWM clock. A new low width is held in a shadow register and applied only when the counter wraps, so a change never cuts a period short. The cycle value and the polarity may change only while the block is disabled. The core also reports the live count, along with one-clock event pulses for the rising edge of the output, its falling edge and each counter wrap. An interval-timer mode keeps the counter and the wrap events running but holds the output at its idle level.

Top module: `pwm_lf_core`

## Requirements
- R1: While `rst` is high, `pwm_o`, `cnt_o`, `rise_o`, `fall_o` and `clr_o` are all zero on the next clock.
- R2: While `en_i` is 0, `cnt_o` is held at 0, `pwm_o` equals `pol_i` (its idle level), and no event pulse fires.
- R3: `psel_i` codes 0, 1, 2 and 3 make the counter advance once every 1, 16, 256 and 2048 clocks.
- R4: One period lasts `cyc_i`+1 ticks. `clr_o` pulses for one clock in the clock where `cnt_o` returns to 0 after holding `cyc_i`.
- R5: With `pol_i`=0 and 0 < `low_i` <= `cyc_i`, each period starts low for `low_i` ticks and is then high for `cyc_i`+1−`low_i` ticks.
- R6: With `pol_i`=0, a `low_i` of 0 keeps the output high for the whole period, and a `low_i` greater than `cyc_i` keeps it low for the whole period. In both cases no edge events occur while running.
- R7: With `pol_i`=1 the levels are swapped. The period starts high for `low_i` ticks and then goes low.
- R8: A `low_i` change made while running takes effect only from the next counter wrap. The current period keeps the old width.
- R9: `rise_o` (or `fall_o`) pulses for one clock in the first clock that `pwm_o` shows a new high (or low) level. Neither pulse fires on the change to the idle level at disable.
- R10: With `tmode_i`=1, `pwm_o` stays at `pol_i` and no edge event fires, while the counter and `clr_o` behave as in R4.
- R11: After `en_i` is first sampled high, the first period begins at count 0, and `cnt_o` becomes 1 after exactly one full divider interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; 0 holds counter and divider at zero |
| tmode_i | input | 1 | Interval-timer mode: output held idle |
| pol_i | input | 1 | 1 swaps output levels (period starts high) |
| psel_i | input | 2 | Divider select: 0→1, 1→16, 2→256, 3→2048 |
| cyc_i | input | CNT_W | Last count value of a period |
| low_i | input | CNT_W | First-phase width in ticks |
| pwm_o | output | 1 | PWM output |
| cnt_o | output | CNT_W | Live counter value |
| rise_o | output | 1 | One-clock pulse on output rising edge |
| fall_o | output | 1 | One-clock pulse on output falling edge |
| clr_o | output | 1 | One-clock pulse on counter wrap |

## Verification
The assertions assume that `cyc_i` is held steady whenever `en_i` is high, so a wrap always follows a count equal to the cycle value seen in the clock before. They also assume that control inputs change only between clock edges. The bench changes cycle, polarity and divider settings only after it has dropped `en_i` for at least one clock. It drives every input on the falling edge. While the block runs, it changes only `low_i`, which is the one field the block is built to accept mid-period.

// File: rtl/pwm_lf_pkg.sv
package pwm_lf_pkg;

  // Divider select codes
  typedef enum logic [1:0] {
    DIV_1    = 2'd0,
    DIV_16   = 2'd1,
    DIV_256  = 2'd2,
    DIV_2048 = 2'd3
  } psel_e;

  localparam int unsigned PSEL_W  = 2;
  localparam int unsigned PSEL_N  = 4;

  // log2 of the division ratio for each select code
  function automatic int unsigned div_shift(input int unsigned code);
    case (code)
      0:       div_shift = 0;
      1:       div_shift = 4;
      2:       div_shift = 8;
      default: div_shift = 11;
    endcase
  endfunction

endpackage

// File: rtl/pwm_lf_prescaler.sv
module pwm_lf_prescaler
  import pwm_lf_pkg::*;
#(
  parameter int unsigned PRE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim_tab [PSEL_N];
  logic [PRE_W-1:0] lim;

  // One terminal value per select code
  for (genvar g = 0; g < PSEL_N; g++) begin : g_lim
    localparam int unsigned SH = div_shift(g);
    assign lim_tab[g] = PRE_W'((1 << SH) - 1);
  end

  assign lim  = lim_tab[psel];
  // >= keeps the divider safe if the select shrinks mid-count
  assign tick = run && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_lf_counter.sv
module pwm_lf_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] low,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] shadow_d,
  output logic             wrap
);

  logic [CNT_W-1:0] shadow_q;

  assign wrap = tick && (cnt_q >= cyc);

  always_comb begin
    if (!run || wrap) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  // Low width is captured while idle and at each wrap only
  assign shadow_d = (!run || wrap) ? low : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
    end
  end

endmodule

// File: rtl/pwm_lf_shaper.sv
module pwm_lf_shaper #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tmode,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] shadow_d,
  input  logic             wrap,
  output logic             pwm_q,
  output logic             rise_q,
  output logic             fall_q,
  output logic             clr_q
);

  logic drive;
  logic level;
  logic pwm_d;

  assign drive = run && !tmode;
  // First phase while count is below the low width
  assign level = (cnt_d >= shadow_d) ^ pol;
  assign pwm_d = drive ? level : pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      pwm_q  <= pwm_d;
      rise_q <= drive && pwm_d && !pwm_q;
      fall_q <= drive && !pwm_d && pwm_q;
      clr_q  <= wrap;
    end
  end

endmodule

// File: rtl/pwm_lf_core.sv
module pwm_lf_core
  import pwm_lf_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned PRE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              tmode_i,
  input  logic              pol_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic [CNT_W-1:0]  cyc_i,
  input  logic [CNT_W-1:0]  low_i,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic              clr_o
);

  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] shadow_d;

  pwm_lf_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (en_i),
    .psel (psel_i),
    .tick (tick)
  );

  pwm_lf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (en_i),
    .tick     (tick),
    .cyc      (cyc_i),
    .low      (low_i),
    .cnt_q    (cnt_o),
    .cnt_d    (cnt_d),
    .shadow_d (shadow_d),
    .wrap     (wrap)
  );

  pwm_lf_shaper #(.CNT_W(CNT_W)) u_shp (
    .clk      (clk),
    .rst      (rst),
    .run      (en_i),
    .tmode    (tmode_i),
    .pol      (pol_i),
    .cnt_d    (cnt_d),
    .shadow_d (shadow_d),
    .wrap     (wrap),
    .pwm_q    (pwm_o),
    .rise_q   (rise_o),
    .fall_q   (fall_o),
    .clr_q    (clr_o)
  );

endmodule

// File: rtl/pwm_lf_core_chk.sv
module pwm_lf_core_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             tmode_i,
  input logic [CNT_W-1:0] cyc_i,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             rise_o,
  input logic             fall_o,
  input logic             clr_o
);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_o == '0) && !clr_o && !rise_o && !fall_o);

  // R9
  rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (pwm_o && !$past(pwm_o)));

  // R9
  fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> (!pwm_o && $past(pwm_o)));

  // R4
  clr_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> ((cnt_o == '0) && ($past(cnt_o) == $past(cyc_i))));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_o != $past(cnt_o)) |-> ((cnt_o == $past(cnt_o) + 1'b1) || (cnt_o == '0)));

  // R10
  tmode_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && tmode_i) |=> (!rise_o && !fall_o));

  // R9
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_o, fall_o}));

endmodule

bind pwm_lf_core pwm_lf_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en_i    (en_i),
  .tmode_i (tmode_i),
  .cyc_i   (cyc_i),
  .pwm_o   (pwm_o),
  .cnt_o   (cnt_o),
  .rise_o  (rise_o),
  .fall_o  (fall_o),
  .clr_o   (clr_o)
);

// File: tb/test_pwm_lf_core.sv
`timescale 1ns/1ps
module test_pwm_lf_core;

  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_i = 1'b0;
  logic          tmode_i = 1'b0;
  logic          pol_i = 1'b0;
  logic [1:0]    psel_i = 2'd0;
  logic [CW-1:0] cyc_i = '0;
  logic [CW-1:0] low_i = '0;
  logic          pwm_o, rise_o, fall_o, clr_o;
  logic [CW-1:0] cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_lf_core i_pwm_lf_core (
    .clk(clk), .rst(rst), .en_i(en_i), .tmode_i(tmode_i), .pol_i(pol_i),
    .psel_i(psel_i), .cyc_i(cyc_i), .low_i(low_i), .pwm_o(pwm_o),
    .cnt_o(cnt_o), .rise_o(rise_o), .fall_o(fall_o), .clr_o(clr_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clr();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (clr_o) return;
    end
  endtask

  // Starts on a clear cycle, ends on the next clear cycle
  task automatic count_period(output int per, output int hi, output int ri,
                              output int fa, output bit first);
    per = 0; hi = 0; ri = 0; fa = 0; first = pwm_o;
    do begin
      per++;
      if (pwm_o) hi++;
      if (rise_o) ri++;
      if (fall_o) fa++;
      @(negedge clk);
    end while (!clr_o && per < 20000);
  endtask

  task automatic setup(input bit pol, input bit tm, input logic [1:0] ps,
                       input int cyc, input int low);
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    pol_i = pol; tmode_i = tm; psel_i = ps;
    cyc_i = CW'(cyc); low_i = CW'(low);
    @(negedge clk);
    en_i = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pwm_o == 0 && cnt_o == 0, "R1 pwm/cnt in reset", {pwm_o, cnt_o}, 0);
    chk(!rise_o && !fall_o && !clr_o, "R1 events in reset", {rise_o, fall_o, clr_o}, 0);
  endtask

  task automatic t_disabled();
    int bad = 0;
    pol_i = 1'b1; cyc_i = 5; low_i = 2;
    en_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_o != 1'b1 || cnt_o != 0 || rise_o || fall_o || clr_o) bad++;
    end
    chk(bad == 0, "R2 idle outputs", bad, 0);
  endtask

  task automatic t_basic();
    int per, hi, ri, fa; bit f;
    setup(0, 0, 2'd0, 9, 3);
    wait_clr();
    count_period(per, hi, ri, fa, f);
    chk(per == 10, "R4 period length", per, 10);
    chk(hi == 7, "R5 high time", hi, 7);
    chk(ri == 1 && fa == 1, "R9 one edge of each kind", ri * 10 + fa, 11);
    chk(f == 0, "R5 period starts low", f, 0);
  endtask

  task automatic t_div(input logic [1:0] ps, input int cyc, input int low,
                       input int exp_per, input int exp_hi);
    int per, hi, ri, fa; bit f;
    setup(0, 0, ps, cyc, low);
    wait_clr();
    count_period(per, hi, ri, fa, f);
    chk(per == exp_per, "R3 divided period", per, exp_per);
    chk(hi == exp_hi, "R3 divided high time", hi, exp_hi);
  endtask

  task automatic t_extremes();
    int per, hi, ri, fa; bit f;
    setup(0, 0, 2'd0, 9, 0);
    wait_clr();
    count_period(per, hi, ri, fa, f);
    chk(hi == 10 && ri == 0 && fa == 0, "R6 zero low width all high", hi, 10);
    setup(0, 0, 2'd0, 9, 11);
    wait_clr();
    count_period(per, hi, ri, fa, f);
    chk(hi == 0 && ri == 0 && fa == 0, "R6 low width above cycle all low", hi, 0);
  endtask

  task automatic t_polarity();
    int per, hi, ri, fa; bit f;
    setup(1, 0, 2'd0, 9, 3);
    wait_clr();
    count_period(per, hi, ri, fa, f);
    chk(hi == 3, "R7 inverted high time", hi, 3);
    chk(f == 1, "R7 period starts high", f, 1);
  endtask

  task automatic t_deferred();
    int per, hi, ri, fa; bit f;
    setup(0, 0, 2'd0, 19, 5);
    wait_clr();
    low_i = 15;
    count_period(per, hi, ri, fa, f);
    chk(hi == 15, "R8 old width kept this period", hi, 15);
    count_period(per, hi, ri, fa, f);
    chk(hi == 5, "R8 new width from next wrap", hi, 5);
  endtask

  task automatic t_tmode();
    int per, hi, ri, fa; bit f;
    setup(0, 1, 2'd0, 9, 3);
    wait_clr();
    count_period(per, hi, ri, fa, f);
    chk(per == 10, "R10 counter still wraps", per, 10);
    chk(hi == 0 && ri == 0 && fa == 0, "R10 output held idle", hi + ri + fa, 0);
  endtask

  task automatic t_start();
    int n = 0;
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    pol_i = 0; tmode_i = 0; psel_i = 2'd1; cyc_i = 3; low_i = 2;
    @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
    n = 1;
    chk(cnt_o == 0 && pwm_o == 0, "R11 first clock at count 0 low", cnt_o, 0);
    while (cnt_o != 1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 16, "R11 first tick after one divider interval", n, 16);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_disabled();
    t_basic();
    t_div(2'd1, 4, 2, 80, 48);
    t_div(2'd2, 1, 1, 512, 256);
    t_div(2'd3, 1, 1, 4096, 2048);
    t_extremes();
    t_polarity();
    t_deferred();
    t_tmode();
    t_start();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule